// File: doc/BRIEF.md
# Software-Filled Set-Associative Translation Buffer

This block holds page translations that software loads one at a time through three 32-bit control registers: an entry-address register (a base field plus the virtual page number to work on), an access register (frame number and permission flags), and a control register (way selector, read and write triggers, and the process ID). A translation lookup compares a virtual page number against every way of one set in parallel. It returns a hit flag, the 20-bit physical frame number, and the read, write, execute and cacheable flags of the matching entry.

The registers share a single write port made of a strobe, a register selector and a data word. Software loads an entry in three steps. It writes the virtual page number into the entry-address register, sets the write-enable bit and way in the control register, and then writes the access register. The way selector advances after each stored entry, so a burst of access writes fills consecutive ways. Setting the read trigger in a control write copies one stored entry back into the readable register values. The values that software writes are held apart from the values it reads back. The page number and process ID used for stores and lookups always come from the last value written.

The default shape is 16 ways by 16 sets with an 8-bit process ID. An entry sits at way W, set (VPN mod 16).

Top module: `tlb_sw_top`

## Requirements
- R1: After reset all three read-back registers are zero and no lookup hits.
- R2: An access-register write while control bit 18 (write enable, as read back) is 0 stores nothing and leaves the way field unchanged.
- R3: An access-register write while control bit 18 is 1 stores an entry in the way given by control bits 23:20 and the set given by the low 4 bits of the last written page number. The page number is entry-address bits 21:2. The process ID is the last written control bits 11:4. The flags are C=bit 24, R=23, W=22, X=21 and global=20, and the frame number is bits 19:0. A lookup of that page number then reports these values.
- R4: After each stored entry, control bits 23:20 read back as the used way plus one, modulo the way count (15 wraps to 0).
- R5: A lookup hits only when a valid entry's page number matches and either its global flag is set or its process ID equals the last written control process ID.
- R6: An entry whose page number is 0xC0000 or above is stored invalid and never hits; 0xBFFFF is valid.
- R7: An entry-address write updates bits 31:22 and 1:0 as read back but leaves the page-number field (bits 21:2) unchanged.
- R8: Writing the access register never changes its read-back value.
- R9: A control write with bit 19 set reads the entry at way (written bits 23:20) and set (last written page number). Access read-back becomes its own bits 31:25, plus the entry's flags and frame, plus bit 20 set if the entry is global. Control read-back becomes the written value with bits 17:4 replaced by the entry's process ID. The entry-address page-number field becomes the entry's page number.
- R10: A control write with bit 19 clear reads back exactly the written value.
- R11: When several ways of a set match, the lowest-numbered way supplies the result.
- R12: A write with selector 3 changes no register and no entry. The selector codes are 0 for entry address, 1 for access and 2 for control.
- R13: On a miss, the frame number and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector: 0 entry address, 1 access, 2 control, 3 none |
| wr_data | input | 32 | Register write data |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number of the hit |
| lk_c | output | 1 | Cacheable flag of the hit |
| lk_r | output | 1 | Read permission of the hit |
| lk_w | output | 1 | Write permission of the hit |
| lk_x | output | 1 | Execute permission of the hit |
| pte_q | output | 32 | Entry-address register read-back |
| acc_q | output | 32 | Access register read-back |
| misc_q | output | 32 | Control register read-back |

## Verification
Two states are the hardest to reach from the ports: two ways of one set holding the same page, and an entry read that must show a process ID different from the one currently in effect. Both depend on the way pointer and the written/read-back split. To build the duplicate, the bench stores the same page twice and picks the way explicitly with a control write each time, storing the higher way first, so the lowest-way rule cannot be mistaken for "last stored wins". The read-back case stores an entry under one process ID and then reads it back with a control write that carries a different ID. It then checks that the control read-back shows the stored ID while lookups follow the written one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int REG_W   = 32;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 20;

    // access register fields
    localparam int ACC_C   = 24;
    localparam int ACC_R   = 23;
    localparam int ACC_W   = 22;
    localparam int ACC_X   = 21;
    localparam int ACC_G   = 20;
    localparam logic [REG_W-1:0] ACC_KEEP_MASK = 32'hFE00_0000;

    // control register fields
    localparam int CTL_WAY_LSB = 20;
    localparam int CTL_WAY_W   = 4;
    localparam int CTL_RD      = 19;
    localparam int CTL_WE      = 18;
    localparam int CTL_PID_LSB = 4;
    localparam logic [REG_W-1:0] CTL_PID_MASK = 32'h0003_FFF0;

    // entry-address register fields
    localparam int PTE_VPN_LSB = 2;
    localparam logic [REG_W-1:0] PTE_VPN_MASK = 32'h003F_FFFC;

    localparam logic [VPN_W-1:0] VALID_LIMIT = 20'hC0000;

    typedef enum logic [1:0] {
        SEL_PTE  = 2'd0,
        SEL_ACC  = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic             g;
        logic             v;
    } tag_t;

    typedef struct packed {
        logic             c;
        logic             r;
        logic             w;
        logic             x;
        logic [PFN_W-1:0] pfn;
    } entry_data_t;

    function automatic entry_data_t acc_unpack(input logic [REG_W-1:0] a);
        entry_data_t d;
        d.c   = a[ACC_C];
        d.r   = a[ACC_R];
        d.w   = a[ACC_W];
        d.x   = a[ACC_X];
        d.pfn = a[PFN_W-1:0];
        return d;
    endfunction

    function automatic logic [REG_W-1:0] acc_pack(input entry_data_t d, input logic g);
        logic [REG_W-1:0] a;
        a = '0;
        a[ACC_C] = d.c;
        a[ACC_R] = d.r;
        a[ACC_W] = d.w;
        a[ACC_X] = d.x;
        a[ACC_G] = g;
        a[PFN_W-1:0] = d.pfn;
        return a;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    parameter int PID_W = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst,
    // entry write
    input  logic                         we,
    input  logic [WAY_W-1:0]             w_way,
    input  logic [SET_W-1:0]             w_set,
    input  tag_t                         w_tag,
    input  logic [PID_W-1:0]             w_pid,
    input  entry_data_t                  w_data,
    // entry read
    input  logic [WAY_W-1:0]             r_way,
    input  logic [SET_W-1:0]             r_set,
    output logic [VPN_W-1:0]             r_vpn,
    output logic                         r_g,
    output logic [PID_W-1:0]             r_pid,
    output entry_data_t                  r_data,
    // lookup row
    input  logic [SET_W-1:0]             lk_set,
    output tag_t        [WAYS-1:0]       row_tag,
    output logic        [WAYS-1:0][PID_W-1:0] row_pid,
    output entry_data_t [WAYS-1:0]       row_data
);

    tag_t             tag_mem  [SETS][WAYS];
    logic [PID_W-1:0] pid_mem  [SETS][WAYS];
    entry_data_t      data_mem [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_mem[s][w] <= '0;
                end
            end
        end else if (we) begin
            tag_mem[w_set][w_way] <= w_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            pid_mem[w_set][w_way]  <= w_pid;
            data_mem[w_set][w_way] <= w_data;
        end
    end

    tag_t rd_tag;
    assign rd_tag = tag_mem[r_set][r_way];
    assign r_vpn  = rd_tag.vpn;
    assign r_g    = rd_tag.g;
    assign r_pid  = pid_mem[r_set][r_way];
    assign r_data = data_mem[r_set][r_way];

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_row
        assign row_tag[gw]  = tag_mem[lk_set][gw];
        assign row_pid[gw]  = pid_mem[lk_set][gw];
        assign row_data[gw] = data_mem[lk_set][gw];
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int PID_W = 8
) (
    input  tag_t        [WAYS-1:0]            row_tag,
    input  logic        [WAYS-1:0][PID_W-1:0] row_pid,
    input  entry_data_t [WAYS-1:0]            row_data,
    input  logic [VPN_W-1:0]                  lk_vpn,
    input  logic [PID_W-1:0]                  cur_pid,
    output logic                              hit,
    output entry_data_t                       hit_data
);

    logic [WAYS-1:0] way_match;

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
        assign way_match[gw] = row_tag[gw].v
                            && (row_tag[gw].vpn == lk_vpn)
                            && (row_tag[gw].g || (row_pid[gw] == cur_pid));
    end

    // lowest-numbered matching way wins: scan downward, last assignment sticks
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                hit      = 1'b1;
                hit_data = row_data[w];
            end
        end
    end

endmodule

// File: rtl/tlb_csr.sv
module tlb_csr
    import tlb_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    parameter int PID_W = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    // entry store write
    output logic               st_we,
    output logic [WAY_W-1:0]   st_way,
    output logic [SET_W-1:0]   st_set,
    output tag_t               st_tag,
    output logic [PID_W-1:0]   st_pid,
    output entry_data_t        st_data,
    // entry store read
    output logic [WAY_W-1:0]   rd_way,
    output logic [SET_W-1:0]   rd_set,
    input  logic [VPN_W-1:0]   rd_vpn,
    input  logic               rd_g,
    input  logic [PID_W-1:0]   rd_pid,
    input  entry_data_t        rd_data,
    // lookup context and read-back
    output logic [PID_W-1:0]   cur_pid,
    output logic [REG_W-1:0]   pte_q,
    output logic [REG_W-1:0]   acc_q,
    output logic [REG_W-1:0]   ctl_q
);

    // written values (used for stores and lookups)
    logic [VPN_W-1:0] wvpn_q;
    logic [PID_W-1:0] wpid_q;
    // read-back values
    logic [REG_W-1:0] pte_rb_q;
    logic [REG_W-1:0] acc_rb_q;
    logic [REG_W-1:0] ctl_rb_q;

    logic is_pte, is_acc, is_ctl, commit, do_read;
    logic [WAY_W-1:0] way_next;
    logic [REG_W-1:0] pid_field;

    assign is_pte  = wr_en && (wr_sel == SEL_PTE);
    assign is_acc  = wr_en && (wr_sel == SEL_ACC);
    assign is_ctl  = wr_en && (wr_sel == SEL_CTL);
    assign commit  = is_acc && ctl_rb_q[CTL_WE];
    assign do_read = is_ctl && wr_data[CTL_RD];

    assign st_we      = commit;
    assign st_way     = ctl_rb_q[CTL_WAY_LSB +: WAY_W];
    assign st_set     = wvpn_q[SET_W-1:0];
    assign st_tag.vpn = wvpn_q;
    assign st_tag.g   = wr_data[ACC_G];
    assign st_tag.v   = (wvpn_q < VALID_LIMIT);
    assign st_pid     = wpid_q;
    assign st_data    = acc_unpack(wr_data);

    assign way_next   = st_way + 1'b1;

    assign rd_way     = wr_data[CTL_WAY_LSB +: WAY_W];
    assign rd_set     = wvpn_q[SET_W-1:0];
    assign pid_field  = REG_W'(rd_pid) << CTL_PID_LSB;

    always_ff @(posedge clk) begin
        if (rst) begin
            wvpn_q   <= '0;
            wpid_q   <= '0;
            pte_rb_q <= '0;
            acc_rb_q <= '0;
            ctl_rb_q <= '0;
        end else begin
            if (is_pte) begin
                wvpn_q   <= wr_data[PTE_VPN_LSB +: VPN_W];
                pte_rb_q <= (wr_data & ~PTE_VPN_MASK) | (pte_rb_q & PTE_VPN_MASK);
            end
            if (commit) begin
                ctl_rb_q[CTL_WAY_LSB +: CTL_WAY_W] <= CTL_WAY_W'(way_next);
            end
            if (is_ctl) begin
                wpid_q <= wr_data[CTL_PID_LSB +: PID_W];
                if (do_read) begin
                    ctl_rb_q <= (wr_data & ~CTL_PID_MASK) | pid_field;
                    acc_rb_q <= (acc_rb_q & ACC_KEEP_MASK) | acc_pack(rd_data, rd_g);
                    pte_rb_q[PTE_VPN_LSB +: VPN_W] <= rd_vpn;
                end else begin
                    ctl_rb_q <= wr_data;
                end
            end
        end
    end

    assign cur_pid = wpid_q;
    assign pte_q   = pte_rb_q;
    assign acc_q   = acc_rb_q;
    assign ctl_q   = ctl_rb_q;

endmodule

// File: rtl/tlb_sw_top.sv
module tlb_sw_top
    import tlb_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    parameter int PID_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [19:0] lk_vpn,
    output logic        lk_hit,
    output logic [19:0] lk_pfn,
    output logic        lk_c,
    output logic        lk_r,
    output logic        lk_w,
    output logic        lk_x,
    output logic [31:0] pte_q,
    output logic [31:0] acc_q,
    output logic [31:0] misc_q
);

    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);

    logic               st_we;
    logic [WAY_W-1:0]   st_way, rd_way;
    logic [SET_W-1:0]   st_set, rd_set;
    tag_t               st_tag;
    logic [PID_W-1:0]   st_pid, rd_pid, cur_pid;
    entry_data_t        st_data, rd_data, hit_data;
    logic [VPN_W-1:0]   rd_vpn;
    logic               rd_g;

    tag_t        [WAYS-1:0]            row_tag;
    logic        [WAYS-1:0][PID_W-1:0] row_pid;
    entry_data_t [WAYS-1:0]            row_data;

    tlb_csr #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (reg_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .st_we   (st_we),
        .st_way  (st_way),
        .st_set  (st_set),
        .st_tag  (st_tag),
        .st_pid  (st_pid),
        .st_data (st_data),
        .rd_way  (rd_way),
        .rd_set  (rd_set),
        .rd_vpn  (rd_vpn),
        .rd_g    (rd_g),
        .rd_pid  (rd_pid),
        .rd_data (rd_data),
        .cur_pid (cur_pid),
        .pte_q   (pte_q),
        .acc_q   (acc_q),
        .ctl_q   (misc_q)
    );

    tlb_store #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (st_we),
        .w_way    (st_way),
        .w_set    (st_set),
        .w_tag    (st_tag),
        .w_pid    (st_pid),
        .w_data   (st_data),
        .r_way    (rd_way),
        .r_set    (rd_set),
        .r_vpn    (rd_vpn),
        .r_g      (rd_g),
        .r_pid    (rd_pid),
        .r_data   (rd_data),
        .lk_set   (lk_vpn[SET_W-1:0]),
        .row_tag  (row_tag),
        .row_pid  (row_pid),
        .row_data (row_data)
    );

    tlb_match #(.WAYS(WAYS), .PID_W(PID_W)) u_match (
        .row_tag  (row_tag),
        .row_pid  (row_pid),
        .row_data (row_data),
        .lk_vpn   (lk_vpn),
        .cur_pid  (cur_pid),
        .hit      (lk_hit),
        .hit_data (hit_data)
    );

    assign lk_pfn = hit_data.pfn;
    assign lk_c   = hit_data.c;
    assign lk_r   = hit_data.r;
    assign lk_w   = hit_data.w;
    assign lk_x   = hit_data.x;

endmodule

// File: rtl/tlb_sw_sva.sv
module tlb_sw_sva #(
    parameter int WAYS = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        lk_hit,
    input logic [19:0] lk_pfn,
    input logic        lk_c,
    input logic        lk_r,
    input logic        lk_w,
    input logic        lk_x,
    input logic [31:0] pte_q,
    input logic [31:0] acc_q,
    input logic [31:0] misc_q
);

    localparam int WAY_W = $clog2(WAYS);

    logic acc_wr, ctl_rd_wr;
    assign acc_wr    = wr_en && (wr_sel == 2'd1);
    assign ctl_rd_wr = wr_en && (wr_sel == 2'd2) && wr_data[19];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pte_q == 32'd0 && acc_q == 32'd0 && misc_q == 32'd0 && !lk_hit));

    p_no_store_way_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !misc_q[18]) |=> $stable(misc_q));

    p_way_step_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && misc_q[18]) |=>
            misc_q[20 +: WAY_W] == WAY_W'($past(misc_q[20 +: WAY_W]) + 1'b1));

    p_pte_base_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=>
            (pte_q[31:22] == $past(wr_data[31:22]) && $stable(pte_q[21:2])));

    p_acc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_wr |=> $stable(acc_q));

    p_ctl_plain_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !wr_data[19]) |=> misc_q == $past(wr_data));

    p_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=>
            ($stable(pte_q) && $stable(acc_q) && $stable(misc_q)));

    p_miss_zero_r13: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == 20'd0 && !lk_c && !lk_r && !lk_w && !lk_x));

endmodule

bind tlb_sw_top tlb_sw_sva #(.WAYS(WAYS)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .lk_c    (lk_c),
    .lk_r    (lk_r),
    .lk_w    (lk_w),
    .lk_x    (lk_x),
    .pte_q   (pte_q),
    .acc_q   (acc_q),
    .misc_q  (misc_q)
);

// File: tb/tb_tlb_sw_top.sv
`timescale 1ns/1ps
module tb_tlb_sw_top;

    localparam logic [1:0] S_PTE = 2'd0, S_ACC = 2'd1, S_CTL = 2'd2, S_NONE = 2'd3;
    localparam logic [31:0] B_WE = 32'h1 << 18;
    localparam logic [31:0] B_RD = 32'h1 << 19;
    localparam logic [31:0] A_C = 32'h1 << 24, A_R = 32'h1 << 23, A_W = 32'h1 << 22,
                            A_X = 32'h1 << 21, A_G = 32'h1 << 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [19:0] lk_vpn = 20'd0;
    logic        lk_hit, lk_c, lk_r, lk_w, lk_x;
    logic [19:0] lk_pfn;
    logic [31:0] pte_q, acc_q, misc_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlb_sw_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_c(lk_c), .lk_r(lk_r),
        .lk_w(lk_w), .lk_x(lk_x), .pte_q(pte_q), .acc_q(acc_q), .misc_q(misc_q)
    );

    function automatic logic [31:0] ctl(input int way, input int pid, input logic [31:0] bits);
        return (32'(way) << 20) | (32'(pid) << 4) | bits;
    endfunction

    function automatic logic [31:0] pte(input logic [19:0] vpn);
        return 32'(vpn) << 2;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = 32'd0;
    endtask

    // look up and compare {hit, c, r, w, x, pfn}
    task automatic look(input string req, input logic [19:0] vpn, input logic hit,
                        input logic [3:0] crwx, input logic [19:0] pfn);
        lk_vpn = vpn;
        #1;
        check(req, $sformatf("lookup %h", vpn),
              {7'd0, lk_hit, lk_c, lk_r, lk_w, lk_x, lk_pfn},
              {7'd0, hit, crwx, pfn});
    endtask

    task automatic t_reset;
        check("R1", "pte_q", pte_q, 32'd0);
        check("R1", "acc_q", acc_q, 32'd0);
        check("R1", "misc_q", misc_q, 32'd0);
        look("R1", 20'h00000, 1'b0, 4'b0000, 20'h0);
        look("R13", 20'h12345, 1'b0, 4'b0000, 20'h0);
    endtask

    task automatic t_no_store;
        wr(S_CTL, ctl(0, 5, 32'd0));
        check("R10", "plain control read-back", misc_q, 32'h0000_0050);
        wr(S_PTE, pte(20'h12345));
        wr(S_ACC, A_C | A_R | A_X | 32'hABCDE);
        check("R8", "acc read-back after write", acc_q, 32'd0);
        check("R2", "way unchanged", misc_q, 32'h0000_0050);
        look("R2", 20'h12345, 1'b0, 4'b0000, 20'h0);
    endtask

    task automatic t_store;
        wr(S_CTL, ctl(3, 5, B_WE));
        wr(S_ACC, A_C | A_R | A_X | 32'hABCDE);
        check("R4", "way step 3->4", misc_q, 32'h0044_0050);
        check("R8", "acc read-back after store", acc_q, 32'd0);
        look("R3", 20'h12345, 1'b1, 4'b1101, 20'hABCDE);
        look("R5", 20'h02345, 1'b0, 4'b0000, 20'h0);
    endtask

    task automatic t_pid;
        wr(S_CTL, ctl(0, 6, 32'd0));
        look("R5", 20'h12345, 1'b0, 4'b0000, 20'h0);
        wr(S_CTL, ctl(7, 6, B_WE));
        wr(S_PTE, pte(20'h22222));
        wr(S_ACC, A_G | A_R | 32'h11111);
        wr(S_CTL, ctl(0, 7, 32'd0));
        look("R5", 20'h22222, 1'b1, 4'b0100, 20'h11111);
        look("R5", 20'h12345, 1'b0, 4'b0000, 20'h0);
        wr(S_CTL, ctl(0, 5, 32'd0));
        look("R5", 20'h12345, 1'b1, 4'b1101, 20'hABCDE);
    endtask

    task automatic t_wrap;
        wr(S_CTL, ctl(15, 5, B_WE));
        wr(S_PTE, pte(20'h44444));
        wr(S_ACC, A_W | 32'h44444);
        check("R4", "way wrap 15->0", misc_q, 32'h0004_0050);
        look("R3", 20'h44444, 1'b1, 4'b0010, 20'h44444);
    endtask

    task automatic t_limit;
        wr(S_PTE, pte(20'hC0001));
        wr(S_ACC, A_G | A_R | 32'h55555);
        check("R4", "way step 0->1", misc_q, 32'h0014_0050);
        look("R6", 20'hC0001, 1'b0, 4'b0000, 20'h0);
        wr(S_PTE, pte(20'hBFFFF));
        wr(S_ACC, A_G | A_R | 32'h66666);
        look("R6", 20'hBFFFF, 1'b1, 4'b0100, 20'h66666);
    endtask

    task automatic t_prio;
        wr(S_CTL, ctl(5, 5, B_WE));
        wr(S_PTE, pte(20'h33333));
        wr(S_ACC, A_R | 32'h00055);
        wr(S_CTL, ctl(2, 5, B_WE));
        wr(S_ACC, A_R | 32'h00022);
        look("R11", 20'h33333, 1'b1, 4'b0100, 20'h00022);
    endtask

    task automatic t_pte_field;
        wr(S_PTE, 32'hFFC0_0003 | pte(20'h12345));
        check("R7", "pte read-back keeps vpn field", pte_q, 32'hFFC0_0003);
    endtask

    task automatic t_read;
        wr(S_CTL, ctl(3, 9, B_RD | 32'h1));
        check("R9", "acc from entry", acc_q, A_C | A_R | A_X | 32'hABCDE);
        check("R9", "control pid from entry", misc_q, 32'h0038_0051);
        check("R9", "pte vpn from entry", pte_q, 32'hFFC4_8D17);
        look("R5", 20'h12345, 1'b0, 4'b0000, 20'h0);
        wr(S_PTE, pte(20'h22222));
        check("R7", "base cleared, vpn kept", pte_q, 32'h0004_8D14);
        wr(S_CTL, ctl(7, 0, B_RD));
        check("R9", "acc global entry", acc_q, A_G | A_R | 32'h11111);
        check("R9", "control pid 6", misc_q, 32'h0078_0060);
        check("R9", "pte vpn 22222", pte_q, 32'h0008_8888);
    endtask

    task automatic t_ignore;
        logic [31:0] p0, a0, m0;
        p0 = pte_q; a0 = acc_q; m0 = misc_q;
        wr(S_NONE, 32'hFFFF_FFFF);
        check("R12", "pte_q", pte_q, p0);
        check("R12", "acc_q", acc_q, a0);
        check("R12", "misc_q", misc_q, m0);
        look("R12", 20'h22222, 1'b1, 4'b0100, 20'h11111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_store();
        t_store();
        t_pid();
        t_wrap();
        t_limit();
        t_prio();
        t_pte_field();
        t_read();
        t_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule